// File: doc/BRIEF.md
# AES Inverse Column Mixing Unit

This block performs the inverse column-mixing step of an AES decryption round on a full 128-bit state. The state is split into four 32-bit columns of four bytes each. Every output byte is the XOR of the four bytes of its column, each first multiplied in GF(2^8) by one of the constants 0x0e, 0x0b, 0x0d or 0x09. No lookup table and no general multiplier is used. Each input byte feeds one doubling chain that produces its x2, x4 and x8 multiples. Each constant product is then an XOR of a few of those multiples: 0x0e = x8^x4^x2, 0x0b = x8^x2^x1, 0x0d = x8^x4^x1, 0x09 = x8^x1.

In a decryption round the unit sits after the round-key addition, and it is skipped in the final round. The pipeline has two register stages and no backpressure. A state presented with `in_valid` is captured in an input register. The mixed result is captured in an output register on the next edge.

Top module: `invmix_unit`

## Requirements
- R1: During and right after a synchronous active-high `rst`, `out_valid` is 0 and `out_state` is all zeros.
- R2: A state sampled with `in_valid` high at rising edge N appears on `out_state`, with `out_valid` high, after rising edge N+1. An edge with `in_valid` low gives `out_valid` low after edge N+1.
- R3: Each 32-bit column is transformed independently. A state whose only nonzero byte lies in one column produces zeros in the other three columns.
- R4: The column with bytes 8e,4d,a1,bc (row 0 first) maps to db,13,53,45. The column 9f,dc,58,9d maps to f2,0a,22,5c.
- R5: Applying the unit to the forward column mix of any state returns that original state.
- R6: Byte 0 of the state is bits [127:120] (row 0, column 0), and bytes are numbered column-major. A state whose only nonzero byte is byte 0 = 0x01 gives the result 0e,09,0d,0b in column 0.
- R7: While no new result is produced, `out_state` holds its previous value.
- R8: States presented on consecutive cycles each produce their own result on consecutive cycles, with no bubble.
- R9: A column whose four bytes are all equal is mapped to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_state` as a state to transform |
| in_state | input | 128 | Input state, byte 0 at bits [127:120], column-major |
| out_valid | output | 1 | Marks `out_state` as a fresh result |
| out_state | output | 128 | Transformed state, same byte order as the input |

## Verification
The hardest behaviour to provoke from the ports is the modular reduction in each doubling stage, because it fires only when the top bit of an intermediate multiple is set. Directed vectors alone cover few of those paths. The stimulus therefore streams many pseudo-random states with a random valid pattern, so that all three doubling stages see high-bit operands in every byte lane. Every cycle is compared against a behavioural bit-serial field multiplier. Round trips through a bench-side forward mix tie the result to an independent definition of the transform.

// File: rtl/invmix_pkg.sv
package invmix_pkg;

    localparam int BYTE_W = 8;
    localparam int ROWS = 4;
    localparam int COL_W = BYTE_W * ROWS;
    localparam int CHAIN_DEPTH = 3;
    localparam logic [BYTE_W-1:0] RED_POLY = 8'h1B;

    typedef logic [BYTE_W-1:0] gbyte_t;

    typedef struct packed {
        gbyte_t x8;
        gbyte_t x4;
        gbyte_t x2;
        gbyte_t x1;
    } dbl_set_t;

    typedef enum logic [1:0] {
        K_0E = 2'd0,
        K_0B = 2'd1,
        K_0D = 2'd2,
        K_09 = 2'd3
    } kcoef_e;

    function automatic gbyte_t gf_double(gbyte_t v);
        gbyte_t r;
        r = {v[BYTE_W-2:0], 1'b0};
        if (v[BYTE_W-1]) begin
            r = r ^ RED_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/gf_dbl_chain.sv
module gf_dbl_chain
    import invmix_pkg::*;
(
    input  gbyte_t   a_in,
    output dbl_set_t mult_out
);

    gbyte_t stage [0:CHAIN_DEPTH];

    assign stage[0] = a_in;

    for (genvar i = 1; i <= CHAIN_DEPTH; i++) begin : g_stage
        assign stage[i] = gf_double(stage[i-1]);
    end

    assign mult_out.x1 = stage[0];
    assign mult_out.x2 = stage[1];
    assign mult_out.x4 = stage[2];
    assign mult_out.x8 = stage[3];

endmodule

// File: rtl/gf_const_term.sv
module gf_const_term
    import invmix_pkg::*;
#(
    parameter kcoef_e K = K_0E
) (
    input  dbl_set_t mult_in,
    output gbyte_t   prod_out
);

    if (K == K_0E) begin : g_0e
        assign prod_out = mult_in.x8 ^ mult_in.x4 ^ mult_in.x2;
    end else if (K == K_0B) begin : g_0b
        assign prod_out = mult_in.x8 ^ mult_in.x2 ^ mult_in.x1;
    end else if (K == K_0D) begin : g_0d
        assign prod_out = mult_in.x8 ^ mult_in.x4 ^ mult_in.x1;
    end else begin : g_09
        assign prod_out = mult_in.x8 ^ mult_in.x1;
    end

endmodule

// File: rtl/invmix_column.sv
module invmix_column
    import invmix_pkg::*;
(
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_out
);

    dbl_set_t mults [ROWS];
    gbyte_t   term  [ROWS][ROWS];
    gbyte_t   acc   [ROWS];

    for (genvar j = 0; j < ROWS; j++) begin : g_in
        gf_dbl_chain u_chain (
            .a_in     (col_in[COL_W-1-BYTE_W*j -: BYTE_W]),
            .mult_out (mults[j])
        );
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar j = 0; j < ROWS; j++) begin : g_term
            localparam int SEL = (j - r + ROWS) % ROWS;
            gf_const_term #(
                .K (kcoef_e'(SEL))
            ) u_term (
                .mult_in  (mults[j]),
                .prod_out (term[r][j])
            );
        end
    end

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            acc[r] = '0;
            for (int j = 0; j < ROWS; j++) begin
                acc[r] = acc[r] ^ term[r][j];
            end
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_out
        assign col_out[COL_W-1-BYTE_W*r -: BYTE_W] = acc[r];
    end

endmodule

// File: rtl/invmix_unit.sv
module invmix_unit
    import invmix_pkg::*;
#(
    parameter int N_COLS = 4,
    localparam int STATE_W = N_COLS * COL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [STATE_W-1:0] in_state,
    output logic               out_valid,
    output logic [STATE_W-1:0] out_state
);

    typedef struct packed {
        logic               s1_vld;
        logic [STATE_W-1:0] s1_dat;
        logic               s2_vld;
        logic [STATE_W-1:0] s2_dat;
    } pipe_t;

    pipe_t              pipe_d;
    pipe_t              pipe_q;
    logic [STATE_W-1:0] mix_res;
    logic               mid_valid;

    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        invmix_column u_col (
            .col_in  (pipe_q.s1_dat[STATE_W-1-COL_W*c -: COL_W]),
            .col_out (mix_res[STATE_W-1-COL_W*c -: COL_W])
        );
    end

    always_comb begin
        pipe_d = pipe_q;
        pipe_d.s1_vld = in_valid;
        if (in_valid) begin
            pipe_d.s1_dat = in_state;
        end
        pipe_d.s2_vld = pipe_q.s1_vld;
        if (pipe_q.s1_vld) begin
            pipe_d.s2_dat = mix_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign mid_valid = pipe_q.s1_vld;
    assign out_valid = pipe_q.s2_vld;
    assign out_state = pipe_q.s2_dat;

endmodule

// File: rtl/invmix_unit_chk.sv
module invmix_unit_chk
    import invmix_pkg::*;
#(
    parameter int N_COLS = 4,
    localparam int STATE_W = N_COLS * COL_W
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [STATE_W-1:0] in_state,
    input logic               mid_valid,
    input logic               out_valid,
    input logic [STATE_W-1:0] out_state
);

    function automatic logic cols_uniform(logic [STATE_W-1:0] s);
        logic ok;
        ok = 1'b1;
        for (int c = 0; c < N_COLS; c++) begin
            for (int r = 1; r < ROWS; r++) begin
                if (s[STATE_W-1-COL_W*c-BYTE_W*r -: BYTE_W] !=
                    s[STATE_W-1-COL_W*c -: BYTE_W]) begin
                    ok = 1'b0;
                end
            end
        end
        return ok;
    endfunction

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && out_state == '0)); // R1

    AST_LATENCY_VALID: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid); // R2

    AST_LATENCY_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid); // R2

    AST_ZERO_MAPS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_state == '0) |-> ##2 (out_state == '0)); // R3

    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !mid_valid |=> $stable(out_state)); // R7

    AST_UNIFORM_FIXED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cols_uniform(in_state)) |-> ##2 (out_state == $past(in_state, 2))); // R9

endmodule

bind invmix_unit invmix_unit_chk #(
    .N_COLS (N_COLS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_state  (in_state),
    .mid_valid (mid_valid),
    .out_valid (out_valid),
    .out_state (out_state)
);

// File: tb/invmix_unit_tb.sv
module invmix_unit_tb;

    localparam int SW = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_state = '0;
    logic          out_valid;
    logic [SW-1:0] out_state;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int cycles = 0;

    always #10 clk = ~clk;

    invmix_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_state  (in_state),
        .out_valid (out_valid),
        .out_state (out_state)
    );

    function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p;
        logic [7:0] x;
        p = 8'h00;
        x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [SW-1:0] mix_ref(logic [SW-1:0] s, bit inverse);
        logic [7:0] k [4];
        logic [SW-1:0] o;
        logic [7:0] acc;
        if (inverse) begin
            k[0] = 8'h0e; k[1] = 8'h0b; k[2] = 8'h0d; k[3] = 8'h09;
        end else begin
            k[0] = 8'h02; k[1] = 8'h03; k[2] = 8'h01; k[3] = 8'h01;
        end
        o = '0;
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                acc = 8'h00;
                for (int j = 0; j < 4; j++) begin
                    acc = acc ^ gmul(s[SW-1-8*(4*c+j) -: 8], k[(j-r+4)%4]);
                end
                o[SW-1-8*(4*c+r) -: 8] = acc;
            end
        end
        return o;
    endfunction

    logic          m1v = 1'b0, m2v = 1'b0;
    logic [SW-1:0] m1d = '0, m2d = '0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m1v <= 1'b0; m1d <= '0; m2v <= 1'b0; m2d <= '0;
        end else begin
            m1v <= in_valid;
            if (in_valid) m1d <= in_state;
            m2v <= m1v;
            if (m1v) m2d <= mix_ref(m1d, 1'b1);
        end
    end

    task automatic check(string req, logic [SW-1:0] act, logic [SW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R2 R7 R8: every-cycle comparison against the behavioural pipeline model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 valid", {127'd0, out_valid}, {127'd0, m2v});
            check("R7/R8 data", out_state, m2d);
        end
    end

    task automatic send_and_check(string req, logic [SW-1:0] d, logic [SW-1:0] exp);
        @(negedge clk);
        in_valid = 1'b1;
        in_state = d;
        @(negedge clk);
        in_valid = 1'b0;
        in_state = '0;
        @(negedge clk);
        check(req, out_state, exp);
        check({req, " valid"}, {127'd0, out_valid}, {127'd0, 1'b1});
    endtask

    always @(posedge clk) begin
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [SW-1:0] x;
        logic [SW-1:0] prev;
        repeat (3) @(negedge clk);
        check("R1 out_valid", {127'd0, out_valid}, '0);
        check("R1 out_state", out_state, '0);
        rst = 1'b0;

        // R4 known vectors in columns 0 and 3
        send_and_check("R4",
            128'h8e4da1bc_00000000_00000000_9fdc589d,
            128'hdb135345_00000000_00000000_f20a225c);

        // R6 byte 0 position
        send_and_check("R6",
            128'h01000000_00000000_00000000_00000000,
            128'h0e090d0b_00000000_00000000_00000000);

        // R3 column isolation (column 2 only)
        send_and_check("R3",
            128'h00000000_00000000_00a70000_00000000,
            mix_ref(128'h00000000_00000000_00a70000_00000000, 1'b1));
        check("R3 other cols", out_state & 128'hffffffff_ffffffff_00000000_ffffffff, '0);

        // R9 uniform columns are fixed points
        send_and_check("R9",
            128'hc6c6c6c6_01010101_ffffffff_80808080,
            128'hc6c6c6c6_01010101_ffffffff_80808080);

        // R7 hold over idle cycles
        prev = out_state;
        repeat (4) @(negedge clk);
        check("R7 hold", out_state, prev);

        // R5 round trips
        for (int t = 0; t < 6; t++) begin
            x = {$urandom, $urandom, $urandom, $urandom};
            send_and_check("R5", mix_ref(x, 1'b0), x);
        end
        send_and_check("R5 edge", mix_ref({SW{1'b1}}, 1'b0), {SW{1'b1}});

        // R8 back-to-back stream with random gaps
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            in_valid = (t < 40) ? 1'b1 : ($urandom % 10 < 7);
            in_state = {$urandom, $urandom, $urandom, $urandom};
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset mid-stream
        in_valid = 1'b1;
        in_state = {4{32'h12345678}};
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 reset again", {127'd0, out_valid}, '0);
        check("R1 reset data", out_state, '0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule